// File: doc/BRIEF.md
# Frozen Count Byte Reader

This block hands a wide counter value to a narrow, slow host without tearing. The host first raises a capture request; the block detects the rising edge of that request in its own clock domain and copies the live count into a snapshot register. The snapshot then stays put while the count keeps moving, so the host can read it in two halves over one byte-wide port.

The halves are chosen by a byte-select line. A rising edge of that line puts the upper byte of the snapshot on the port, and a falling edge puts the lower byte there. Between edges the port keeps the last byte it was given. Both host lines are asynchronous to the block clock and pass through a two-flop synchronizer before their edges are detected; the block clock is assumed to be much faster than the host toggles them. Both host lines are expected to be low while reset is asserted.

Top module: `sbp_top`

## Requirements
- R1: While reset is asserted, the snapshot and the byte port both read zero.
- R2: A rising edge on the capture request loads the live count into the snapshot; the new value appears on the third rising clock edge after the request goes high (two synchronizer flops, then the capture register), and the count is sampled at that edge.
- R3: Without a new rising edge of the capture request, the snapshot does not change, whatever the live count does; a falling edge of the request has no effect.
- R4: A rising edge on byte-select drives the snapshot's upper byte (bits 15 down to 8) onto the port on the third rising clock edge after the line goes high.
- R5: A falling edge on byte-select drives the snapshot's lower byte (bits 7 down to 0) onto the port on the third rising clock edge after the line goes low.
- R6: Between byte-select edges the port holds its last byte, even if a new capture replaces the snapshot; the next byte-select edge then shows a byte of the new snapshot.
- R7: When a capture edge and a byte-select edge are detected in the same clock cycle, the byte driven comes from the newly captured count, not the previous snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 16 | Live count to be captured |
| latch_req_i | input | 1 | Host capture request, asynchronous |
| byte_sel_i | input | 1 | Host byte-select line, asynchronous; high half on rise, low half on fall |
| data_o | output | 8 | Byte-wide read port |
| snap_o | output | 16 | Frozen snapshot of the count |

## Verification
The capture path and the byte-select path can both see an edge in the same clock cycle, and then the byte mux must take the count being captured rather than the stale snapshot. The bench raises both host lines on the same clock cycle so their synchronized edges coincide, and expects the upper byte of the fresh count on the port while the snapshot reads that count too. A capture placed between the two byte-select edges of a read is checked separately: the port must keep the old byte until the next select edge.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int CNT_W_DEF   = 16;
  localparam int BYTE_W_DEF  = 8;
  localparam int SYNC_N_DEF  = 2;

  typedef enum logic [1:0] {
    PICK_KEEP = 2'd0,
    PICK_HI   = 2'd1,
    PICK_LO   = 2'd2
  } pick_e;
endpackage

// File: rtl/sbp_sync_edge.sv
module sbp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int TOP = STAGES;

  // pipe_q[0..STAGES-1] form the synchronizer, pipe_q[STAGES] is the history bit
  logic [TOP:0] pipe_q;
  logic [TOP:0] pipe_d;

  always_comb begin
    pipe_d[0] = line_i;
    for (int k = 1; k <= TOP; k++) begin
      pipe_d[k] = pipe_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o =  pipe_q[TOP-1] & ~pipe_q[TOP];
  assign fall_o = ~pipe_q[TOP-1] &  pipe_q[TOP];
endmodule

// File: rtl/sbp_snapshot.sv
module sbp_snapshot #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] snap_q_o,
  output logic [W-1:0] snap_nx_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  // forwarded next value lets a same-cycle read see the fresh capture
  always_comb begin
    snap_d = cap_i ? count_i : snap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
    end else if (cap_i) begin
      snap_q <= snap_d;
    end
  end

  assign snap_q_o  = snap_q;
  assign snap_nx_o = snap_d;
endmodule

// File: rtl/sbp_byte_mux.sv
module sbp_byte_mux
  import sbp_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pick_e         pick_i,
  input  logic [W-1:0]  src_i,
  output logic [BW-1:0] byte_o
);
  localparam int HI_LSB = W - BW;

  logic [BW-1:0] byte_q;
  logic [BW-1:0] byte_d;
  logic          byte_en;

  always_comb begin
    byte_en = 1'b0;
    byte_d  = byte_q;
    case (pick_i)
      PICK_HI: begin
        byte_en = 1'b1;
        byte_d  = src_i[HI_LSB +: BW];
      end
      PICK_LO: begin
        byte_en = 1'b1;
        byte_d  = src_i[BW-1:0];
      end
      default: begin
        byte_en = 1'b0;
        byte_d  = byte_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= byte_d;
    end
  end

  assign byte_o = byte_q;
endmodule

// File: rtl/sbp_top.sv
module sbp_top
  import sbp_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int BYTE_W = BYTE_W_DEF,
  parameter int SYNC_N = SYNC_N_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              latch_req_i,
  input  logic              byte_sel_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [CNT_W-1:0]  snap_o
);
  logic cap_rise;
  logic cap_fall_unused;
  logic sel_rise;
  logic sel_fall;
  logic [CNT_W-1:0] snap_nx;
  pick_e pick;

  sbp_sync_edge #(.STAGES(SYNC_N)) u_cap_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (latch_req_i),
    .rise_o (cap_rise),
    .fall_o (cap_fall_unused)
  );

  sbp_sync_edge #(.STAGES(SYNC_N)) u_sel_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (byte_sel_i),
    .rise_o (sel_rise),
    .fall_o (sel_fall)
  );

  sbp_snapshot #(.W(CNT_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap_rise),
    .count_i   (count_i),
    .snap_q_o  (snap_o),
    .snap_nx_o (snap_nx)
  );

  always_comb begin
    if (sel_rise)      pick = PICK_HI;
    else if (sel_fall) pick = PICK_LO;
    else               pick = PICK_KEEP;
  end

  sbp_byte_mux #(.W(CNT_W), .BW(BYTE_W)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pick_i (pick),
    .src_i  (snap_nx),
    .byte_o (data_o)
  );

  // falling edge of the capture request is deliberately unused
  logic unused_ok;
  assign unused_ok = cap_fall_unused;
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  count_i,
  input logic              latch_req_i,
  input logic              byte_sel_i,
  input logic [BYTE_W-1:0] data_o,
  input logic [CNT_W-1:0]  snap_o
);
  localparam int HI_LSB = CNT_W - BYTE_W;

  // independent view of the host lines, delayed like the ports require
  logic [SYNC_N:0] lq;
  logic [SYNC_N:0] sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lq <= '0;
      sq <= '0;
    end else begin
      lq <= {lq[SYNC_N-1:0], latch_req_i};
      sq <= {sq[SYNC_N-1:0], byte_sel_i};
    end
  end

  logic cap_e, hi_e, lo_e;
  assign cap_e = lq[SYNC_N-1] & ~lq[SYNC_N];
  assign hi_e  = sq[SYNC_N-1] & ~sq[SYNC_N];
  assign lo_e  = ~sq[SYNC_N-1] & sq[SYNC_N];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (snap_o == '0 && data_o == '0);
    end
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_e |=> snap_o == $past(count_i));

  p_snap_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_e |=> $stable(snap_o));

  p_high_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_e && !cap_e) |=> data_o == $past(snap_o[HI_LSB +: BYTE_W]));

  p_low_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_e && !cap_e) |=> data_o == $past(snap_o[BYTE_W-1:0]));

  p_port_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_e && !lo_e) |=> $stable(data_o));

  p_fresh_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_e && cap_e) |=> data_o == $past(count_i[HI_LSB +: BYTE_W]));

  p_fresh_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_e && cap_e) |=> data_o == $past(count_i[BYTE_W-1:0]));
endmodule

bind sbp_top sbp_checker #(
  .CNT_W  (CNT_W),
  .BYTE_W (BYTE_W),
  .SYNC_N (SYNC_N)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .count_i     (count_i),
  .latch_req_i (latch_req_i),
  .byte_sel_i  (byte_sel_i),
  .data_o      (data_o),
  .snap_o      (snap_o)
);

// File: tb/sbp_top_tb.sv
module sbp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] count;
  logic        latch_req;
  logic        byte_sel;
  logic [7:0]  data;
  logic [15:0] snap;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sbp_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .count_i     (count),
    .latch_req_i (latch_req),
    .byte_sel_i  (byte_sel),
    .data_o      (data),
    .snap_o      (snap)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b1; count = 16'h0; latch_req = 1'b0; byte_sel = 1'b0;
    #1 rst_n = 1'b0;
    step(3);
    check("R1 snapshot in reset", snap, 16'h0000);
    check("R1 port in reset", {8'h00, data}, 16'h0000);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_capture;
    count = 16'hA5C3;
    latch_req = 1'b1;
    step(2);
    check("R2 not yet captured after two edges", snap, 16'h0000);
    step(1);
    check("R2 captured on third edge", snap, 16'hA5C3);
    count = 16'h7777;
    step(4);
    check("R3 held while request high", snap, 16'hA5C3);
    latch_req = 1'b0;
    count = 16'h1111;
    step(5);
    check("R3 falling request no capture", snap, 16'hA5C3);
  endtask

  task automatic t_read;
    byte_sel = 1'b1;
    step(2);
    check("R4 port unchanged before third edge", {8'h00, data}, 16'h0000);
    step(1);
    check("R4 high byte", {8'h00, data}, 16'h00A5);
    step(6);
    check("R6 port holds between edges", {8'h00, data}, 16'h00A5);
    byte_sel = 1'b0;
    step(3);
    check("R5 low byte", {8'h00, data}, 16'h00C3);
  endtask

  task automatic t_overwrite;
    byte_sel = 1'b1;
    step(4);
    check("R4 high byte before overwrite", {8'h00, data}, 16'h00A5);
    count = 16'h1234;
    latch_req = 1'b1;
    step(4);
    check("R2 overwrite mid-read", snap, 16'h1234);
    check("R6 port keeps old byte", {8'h00, data}, 16'h00A5);
    latch_req = 1'b0;
    byte_sel = 1'b0;
    step(3);
    check("R6 next edge shows new snapshot", {8'h00, data}, 16'h0034);
  endtask

  task automatic t_same_cycle;
    count = 16'hBEEF;
    latch_req = 1'b1;
    byte_sel = 1'b1;
    step(3);
    check("R7 fresh high byte", {8'h00, data}, 16'h00BE);
    check("R7 snapshot", snap, 16'hBEEF);
    latch_req = 1'b0;
    step(2);
    count = 16'h4D2A;
    latch_req = 1'b1;
    byte_sel = 1'b0;
    step(3);
    check("R7 fresh low byte", {8'h00, data}, 16'h002A);
    latch_req = 1'b0;
    step(2);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] v;
      v = 16'h0F0F ^ (16'h1357 * (i + 1));
      count = v;
      latch_req = 1'b1;
      step(3);
      latch_req = 1'b0;
      count = ~v;
      check("R2 sweep capture", snap, v);
      byte_sel = 1'b1;
      step(3);
      check("R4 sweep high", {8'h00, data}, {8'h00, v[15:8]});
      byte_sel = 1'b0;
      step(3);
      check("R5 sweep low", {8'h00, data}, {8'h00, v[7:0]});
      check("R3 sweep hold", snap, v);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_capture();
    t_read();
    t_overwrite();
    t_same_cycle();
    t_sweep();
    step(2);
    finish_run();
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule